// File: doc/BRIEF.md
# Paired-Page TLB Entry Translator

This block takes a single translation entry that has already been matched for an access and turns it into a result. The entry describes two neighbouring virtual pages, an even one and an odd one. The address bit just above the page offset picks which of the two halves applies. The page size is set per access by a power-of-two exponent. The block checks the selected half against the access kind and the current privilege level, in a fixed priority order. It returns either a physical address with a success code or a fault code.

The logic is a single combinational path. A parameter can add one output register stage. With the default setting (`REG_OUT = 1`) the result for the inputs present at a rising clock edge appears on the outputs just after that edge. The caller searches for the entry, refills it and raises any exception. This block only reports the outcome.

Top module: `tlb_pair_xlate`

## Requirements
- R1: While `rst_ni` is low, and until the first clock edge after it is released, `code_o` is 1 (invalid) and `pa_o` is 0.
- R2: With `REG_OUT = 1`, the outputs show the result for the inputs sampled at the previous rising edge. Codes: 0 ok, 1 invalid, 2 fetch from non-executable page, 3 load from non-readable page, 4 privilege violation, 5 store to clean page.
- R3: If virtual address bit `va_i[pg_exp_i]` is 0, the even half `even_i` is used. If it is 1, the odd half `odd_i` is used.
- R4: Each half is 43 bits: [42] valid, [41] dirty, [40:39] level, [38] no-execute, [37] no-read, [36] restricted, [35:0] page number. If the valid bit is 0, the result is code 1, whatever the other fields hold.
- R5: A fetch (`acc_i` = 0) to a valid half with no-execute set gives code 2. This takes priority over the privilege and dirty checks.
- R6: A load (`acc_i` = 1) to a valid half with no-read set gives code 3. This takes priority over the privilege check. The no-execute bit has no effect on a load.
- R7: If restricted = 0, code 4 results when `cur_plv_i` is numerically greater than the half's level.
- R8: If restricted = 1, code 4 results when `cur_plv_i` differs from the half's level in either direction.
- R9: A store (`acc_i` = 2) that passes all earlier checks but finds dirty = 0 gives code 5. A store is not affected by no-execute or no-read.
- R10: On success, `pa_o` = ({page number with bits [pg_exp_i-13:0] cleared}, 12 zero bits) OR (`va_i` with only bits below `pg_exp_i` kept). `pg_exp_i` ranges from 12 to 30.
- R11: Access kind 3 checks only the valid bit and privilege. No-execute, no-read and dirty have no effect on it.
- R12: Whenever `code_o` is not 0, `pa_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low synchronous reset |
| va_i | input | 48 | Virtual address of the access |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 other |
| cur_plv_i | input | 2 | Current privilege level |
| pg_exp_i | input | 5 | Page-size exponent, 12 to 30 |
| even_i | input | 43 | Entry half for the even page |
| odd_i | input | 43 | Entry half for the odd page |
| pa_o | output | 48 | Translated physical address |
| code_o | output | 3 | Result code |

## Verification
The hardest case to reach from the ports is a fault that only shows when a higher-priority check is deliberately passed while a lower one is armed. Examples are a store to a clean page that also carries no-execute and no-read bits, or a privilege violation on a half whose other half is invalid. The stimulus builds the two halves separately so that each sits on one side of a single check. It flips exactly the address bit at the page-size exponent to move between them. The page-number masking is covered by filling the low page-number bits with ones at 4 KiB, 16 KiB, 2 MiB and 1 GiB pages, so any leak of those bits shows up in the address.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VA_W   = 48;
    localparam int PA_W   = 48;
    localparam int OFF_W  = 12;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int PLV_W  = 2;
    localparam int EXP_W  = 5;
    localparam int HALF_W = PPN_W + PLV_W + 5;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_OTHER = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_INVALID = 3'd1,
        RC_NOEXEC  = 3'd2,
        RC_NOREAD  = 3'd3,
        RC_PRIV    = 3'd4,
        RC_CLEAN   = 3'd5
    } rc_e;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [PLV_W-1:0] lvl;
        logic             no_exec;
        logic             no_read;
        logic             strict;
        logic [PPN_W-1:0] ppn;
    } half_t;

    typedef struct packed {
        logic [PA_W-1:0] pa;
        rc_e             code;
    } res_t;
endpackage

// File: rtl/tlbx_half_sel.sv
module tlbx_half_sel
    import tlbx_pkg::*;
(
    input  logic [VA_W-1:0]   va,
    input  logic [EXP_W-1:0]  pg_exp,
    input  logic [HALF_W-1:0] even_raw,
    input  logic [HALF_W-1:0] odd_raw,
    output half_t             sel
);
    logic odd_pick;

    always_comb begin
        odd_pick = va[pg_exp];
        sel      = odd_pick ? half_t'(odd_raw) : half_t'(even_raw);
    end
endmodule

// File: rtl/tlbx_perm_chk.sv
module tlbx_perm_chk
    import tlbx_pkg::*;
(
    input  half_t            h,
    input  acc_e             acc,
    input  logic [PLV_W-1:0] cur_plv,
    output rc_e              code
);
    logic lvl_bad;

    always_comb begin
        lvl_bad = h.strict ? (cur_plv != h.lvl) : (cur_plv > h.lvl);
        if (!h.valid)
            code = RC_INVALID;
        else if (acc == ACC_FETCH && h.no_exec)
            code = RC_NOEXEC;
        else if (acc == ACC_LOAD && h.no_read)
            code = RC_NOREAD;
        else if (lvl_bad)
            code = RC_PRIV;
        else if (acc == ACC_STORE && !h.dirty)
            code = RC_CLEAN;
        else
            code = RC_OK;
    end
endmodule

// File: rtl/tlbx_addr_form.sv
module tlbx_addr_form
    import tlbx_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic [EXP_W-1:0] pg_exp,
    input  logic [PPN_W-1:0] ppn,
    output logic [PA_W-1:0]  pa
);
    logic [EXP_W-1:0] sw_bits;
    logic [PPN_W-1:0] ppn_keep;
    logic [PA_W-1:0]  off_mask;
    logic [PA_W-1:0]  va_pa;

    always_comb begin
        sw_bits  = pg_exp - EXP_W'(OFF_W);
        ppn_keep = ~((PPN_W'(1) << sw_bits) - PPN_W'(1));
        off_mask = (PA_W'(1) << pg_exp) - PA_W'(1);
        va_pa    = PA_W'(va);
        pa       = {ppn & ppn_keep, {OFF_W{1'b0}}} | (va_pa & off_mask);
    end
endmodule

// File: rtl/tlb_pair_xlate.sv
module tlb_pair_xlate
    import tlbx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [VA_W-1:0]   va_i,
    input  logic [1:0]        acc_i,
    input  logic [PLV_W-1:0]  cur_plv_i,
    input  logic [EXP_W-1:0]  pg_exp_i,
    input  logic [HALF_W-1:0] even_i,
    input  logic [HALF_W-1:0] odd_i,
    output logic [PA_W-1:0]   pa_o,
    output logic [2:0]        code_o
);
    localparam res_t RES_RST = '{pa: '0, code: RC_INVALID};

    half_t           half_sel;
    rc_e             chk_code;
    logic [PA_W-1:0] raw_pa;
    res_t            res_d;
    res_t            res_q;

    tlbx_half_sel u_sel (
        .va       (va_i),
        .pg_exp   (pg_exp_i),
        .even_raw (even_i),
        .odd_raw  (odd_i),
        .sel      (half_sel)
    );

    tlbx_perm_chk u_chk (
        .h       (half_sel),
        .acc     (acc_e'(acc_i)),
        .cur_plv (cur_plv_i),
        .code    (chk_code)
    );

    tlbx_addr_form u_addr (
        .va     (va_i),
        .pg_exp (pg_exp_i),
        .ppn    (half_sel.ppn),
        .pa     (raw_pa)
    );

    always_comb begin
        res_d      = RES_RST;
        res_d.code = chk_code;
        res_d.pa   = (chk_code == RC_OK) ? raw_pa : '0;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk_i) begin
                if (!rst_ni)
                    res_q <= RES_RST;
                else
                    res_q <= res_d;
            end
        end else begin : g_comb
            always_comb res_q = res_d;
        end
    endgenerate

    assign pa_o   = res_q.pa;
    assign code_o = res_q.code;
endmodule

// File: rtl/tlbx_checker.sv
module tlbx_checker
    import tlbx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [VA_W-1:0]   va_i,
    input logic [1:0]        acc_i,
    input logic [PLV_W-1:0]  cur_plv_i,
    input logic [EXP_W-1:0]  pg_exp_i,
    input logic [HALF_W-1:0] even_i,
    input logic [HALF_W-1:0] odd_i,
    input logic [PA_W-1:0]   pa_o,
    input logic [2:0]        code_o
);
    generate
        if (REG_OUT) begin : g_props
            // R2: the result code stays inside the defined set
            a_r2_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
                code_o <= 3'd5);

            // R12: a fault never carries an address
            a_r12_fault_no_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
                code_o != 3'd0 |-> pa_o == '0);

            // R10: the 4 KiB offset always passes through on success
            a_r10_low_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && code_o == 3'd0) |-> pa_o[11:0] == $past(va_i[11:0]));

            // R9: a store never reports the fetch or load faults
            a_r9_store_kinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && $past(acc_i) == 2'd2) |-> (code_o != 3'd2 && code_o != 3'd3));

            // R5: a fetch never reports the load or clean-page faults
            a_r5_fetch_kinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && $past(acc_i) == 2'd0) |-> (code_o != 3'd3 && code_o != 3'd5));

            // R10: the page exponent stays inside the supported range
            a_r10_exp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (pg_exp_i >= 5'd12 && pg_exp_i <= 5'd30));

            // R2: identical inputs over two edges give identical outputs
            a_r2_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && $stable(va_i) && $stable(acc_i) && $stable(cur_plv_i) &&
                 $stable(pg_exp_i) && $stable(even_i) && $stable(odd_i))
                |=> ($stable(code_o) && $stable(pa_o)));
        end
    endgenerate
endmodule

bind tlb_pair_xlate tlbx_checker #(.REG_OUT(REG_OUT)) u_props (.*);

// File: tb/tlb_pair_xlate_test.sv
`timescale 1ns/1ps
module tlb_pair_xlate_test;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [47:0] va_i = '0;
    logic [1:0]  acc_i = '0;
    logic [1:0]  cur_plv_i = '0;
    logic [4:0]  pg_exp_i = 5'd12;
    logic [42:0] even_i = '0;
    logic [42:0] odd_i = '0;
    logic [47:0] pa_o;
    logic [2:0]  code_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0]  code;
        logic [47:0] pa;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk_i = ~clk_i;

    tlb_pair_xlate #(.REG_OUT(1'b1)) uut (.*);

    function automatic logic [42:0] mk(bit v, bit d, logic [1:0] lvl, bit nx, bit nr,
                                       bit st, logic [35:0] ppn);
        return {v, d, lvl, nx, nr, st, ppn};
    endfunction

    function automatic exp_t model(logic [47:0] va, logic [1:0] acc, logic [1:0] cur,
                                   logic [4:0] ps, logic [42:0] h0, logic [42:0] h1);
        exp_t e;
        logic [42:0] h;
        logic [35:0] ppn;
        logic [47:0] pa;
        bit bad;
        h = va[ps] ? h1 : h0;
        bad = h[36] ? (cur != h[40:39]) : (cur > h[40:39]);
        if (!h[42])                     e.code = 3'd1;
        else if (acc == 2'd0 && h[38])  e.code = 3'd2;
        else if (acc == 2'd1 && h[37])  e.code = 3'd3;
        else if (bad)                   e.code = 3'd4;
        else if (acc == 2'd2 && !h[41]) e.code = 3'd5;
        else                            e.code = 3'd0;
        ppn = h[35:0];
        for (int i = 0; i < 36; i++) if (i < int'(ps) - 12) ppn[i] = 1'b0;
        pa = {ppn, 12'h000};
        for (int i = 0; i < 48; i++) if (i < int'(ps)) pa[i] = va[i];
        e.pa = (e.code == 3'd0) ? pa : 48'h0;
        e.tag = "";
        return e;
    endfunction

    task automatic send(string tag, logic [47:0] va, logic [1:0] acc, logic [1:0] cur,
                        logic [4:0] ps, logic [42:0] h0, logic [42:0] h1);
        exp_t e;
        @(negedge clk_i);
        va_i = va; acc_i = acc; cur_plv_i = cur; pg_exp_i = ps; even_i = h0; odd_i = h1;
        e = model(va, acc, cur, ps, h0, h1);
        e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk_i);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_run++;
                if (code_o !== e.code || pa_o !== e.pa) begin
                    n_fail++;
                    $display("FAIL %s (R2 timing): code=%0d pa=%h expected code=%0d pa=%h",
                             e.tag, code_o, pa_o, e.code, e.pa);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk_i);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: done=0 expected done=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        logic [42:0] ok_rw;
        ok_rw = mk(1, 1, 2'd3, 0, 0, 0, 36'h0_0ABC_DEF1);
        repeat (3) @(posedge clk_i);
        #2;
        n_run++;
        if (code_o !== 3'd1 || pa_o !== 48'h0) begin
            n_fail++;
            $display("FAIL R1 reset: code=%0d pa=%h expected code=1 pa=0", code_o, pa_o);
        end
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R4 invalid dominates everything
        send("R4 invalid fetch nx", 48'h0000_0000_1000, 2'd0, 2'd3, 5'd12,
             mk(0, 0, 2'd0, 1, 1, 1, 36'h1), mk(0, 0, 2'd0, 1, 1, 1, 36'h2));
        send("R4 invalid store clean", 48'h0000_0000_0000, 2'd2, 2'd0, 5'd12,
             mk(0, 0, 2'd3, 0, 0, 0, 36'h3), ok_rw);
        // R3 half selection at three page sizes
        send("R3 4K odd", 48'h0000_1234_5678 | 48'h1000, 2'd1, 2'd0, 5'd12,
             mk(0, 1, 2'd3, 0, 0, 0, 36'h5), ok_rw);
        send("R3 4K even", 48'h0000_1234_4678, 2'd1, 2'd0, 5'd12,
             mk(0, 1, 2'd3, 0, 0, 0, 36'h5), ok_rw);
        send("R3 16K odd", 48'h0000_0000_4ABC, 2'd1, 2'd0, 5'd14,
             ok_rw, mk(0, 1, 2'd3, 0, 0, 0, 36'h7));
        send("R3 16K even", 48'h0000_0000_8ABC, 2'd1, 2'd0, 5'd14,
             ok_rw, mk(0, 1, 2'd3, 0, 0, 0, 36'h7));
        send("R3 2M odd", 48'h7FFF_FFFF_FFFF & 48'h0000_003F_FFFF, 2'd1, 2'd0, 5'd21,
             mk(0, 1, 2'd3, 0, 0, 0, 36'h9), ok_rw);
        // R5 fetch no-execute ahead of privilege
        send("R5 fetch nx over priv", 48'h0000_0000_0123, 2'd0, 2'd3, 5'd12,
             mk(1, 0, 2'd0, 1, 0, 0, 36'h11), ok_rw);
        send("R5 fetch allowed", 48'h0000_0000_0123, 2'd0, 2'd0, 5'd12,
             mk(1, 0, 2'd0, 0, 1, 0, 36'h11), ok_rw);
        // R6 load no-read ahead of privilege; nx ignored
        send("R6 load nr over priv", 48'h0000_0000_0456, 2'd1, 2'd3, 5'd12,
             mk(1, 1, 2'd0, 0, 1, 1, 36'h22), ok_rw);
        send("R6 load ignores nx", 48'h0000_0000_0456, 2'd1, 2'd1, 5'd12,
             mk(1, 1, 2'd1, 1, 0, 0, 36'h22), ok_rw);
        // R7 ordered privilege
        send("R7 cur above lvl", 48'h0000_0000_0789, 2'd1, 2'd3, 5'd12,
             mk(1, 1, 2'd0, 0, 0, 0, 36'h33), ok_rw);
        send("R7 cur below lvl", 48'h0000_0000_0789, 2'd1, 2'd0, 5'd12,
             mk(1, 1, 2'd3, 0, 0, 0, 36'h33), ok_rw);
        send("R7 cur equal lvl", 48'h0000_0000_0789, 2'd1, 2'd2, 5'd12,
             mk(1, 1, 2'd2, 0, 0, 0, 36'h33), ok_rw);
        // R8 restricted privilege
        send("R8 strict lower cur", 48'h0000_0000_0ABC, 2'd1, 2'd0, 5'd12,
             mk(1, 1, 2'd3, 0, 0, 1, 36'h44), ok_rw);
        send("R8 strict equal", 48'h0000_0000_0ABC, 2'd1, 2'd3, 5'd12,
             mk(1, 1, 2'd3, 0, 0, 1, 36'h44), ok_rw);
        // R9 store to clean page, after privilege
        send("R9 store clean", 48'h0000_0000_0DEF, 2'd2, 2'd0, 5'd12,
             mk(1, 0, 2'd3, 1, 1, 0, 36'h55), ok_rw);
        send("R9 priv before clean", 48'h0000_0000_0DEF, 2'd2, 2'd2, 5'd12,
             mk(1, 0, 2'd1, 0, 0, 0, 36'h55), ok_rw);
        send("R9 store dirty nx nr", 48'h0000_0000_0DEF, 2'd2, 2'd1, 5'd12,
             mk(1, 1, 2'd1, 1, 1, 0, 36'h55), ok_rw);
        // R10 address forming with software bits cleared
        send("R10 4K pa", 48'h0000_0000_0FED, 2'd1, 2'd0, 5'd12,
             mk(1, 1, 2'd0, 0, 0, 0, 36'h8_7654_3210), ok_rw);
        send("R10 16K pa", 48'h0000_0000_3FED, 2'd1, 2'd0, 5'd14,
             mk(1, 1, 2'd0, 0, 0, 0, 36'h8_7654_321F), ok_rw);
        send("R10 2M pa", 48'h0000_001F_FFFF, 2'd1, 2'd0, 5'd21,
             mk(1, 1, 2'd0, 0, 0, 0, 36'hF_FFFF_FFFF), ok_rw);
        send("R10 1G pa", 48'h0000_1234_5678 & 48'h0000_3FFF_FFFF, 2'd1, 2'd0, 5'd30,
             mk(1, 1, 2'd0, 0, 0, 0, 36'hA_BCDF_FFFF), ok_rw);
        // R11 other access kind
        send("R11 other ignores nx nr d", 48'h0000_0000_0111, 2'd3, 2'd0, 5'd12,
             mk(1, 0, 2'd0, 1, 1, 0, 36'h66), ok_rw);
        send("R11 other priv", 48'h0000_0000_0111, 2'd3, 2'd2, 5'd12,
             mk(1, 0, 2'd1, 1, 1, 0, 36'h66), ok_rw);
        // R12 fault after a success leaves no address
        send("R12 ok then", 48'h0000_0000_0222, 2'd1, 2'd0, 5'd12, ok_rw, ok_rw);
        send("R12 fault zero pa", 48'h0000_0000_0222, 2'd1, 2'd3, 5'd12,
             mk(1, 1, 2'd0, 0, 0, 0, 36'hF_FFFF_FFFF), ok_rw);

        repeat (4) @(posedge clk_i);
        #3;
        n_run++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2 pending results: left=%0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule